// File: doc/BRIEF.md
# Macro Instruction Execution Core

This block runs a short stored program of 32-bit instructions against eight 32-bit working registers. A pulse on `start` while idle loads the program counter and the program base from `start_addr`. The core then alternates between a fetch cycle, which drives the byte address on the instruction read port, and an execute cycle, which decodes the word that the port returns one clock later. Instructions read operands from a parameter FIFO and send method writes (a method address and a 32-bit value) to a downstream engine.

Every instruction word has the same low fields: operation `[2:0]`, exit flag `[3]`, action `[5:4]`, destination register `[8:6]`, operand-A register `[11:9]` and operand-B register `[14:12]`. ALU instructions carry a function code in `[19:15]`. Immediates are the signed 14-bit field `[31:18]`. Bitfield instructions carry a source bit position in `[19:15]`, a width in `[24:20]` (mask = 2^width − 1) and a destination bit position in `[29:25]`. Branches (operation 7) use bit 4 to select the condition and bit 5 to suppress the delay slot.

Top module: `macro_core`

## Requirements
- R1: After reset `busy`, `mw_valid`, `err` and `prm_ready` are low. A `start` pulse while idle raises `busy` on the next cycle, and `imem_addr` then equals `start_addr`.
- R2: Each instruction takes one fetch cycle and at least one execute cycle. On fall-through the next fetch address is the previous one plus 4.
- R3: Operation 0 is an ALU operation on A and B, with function code in `[19:15]`: 0 add, 1 subtract (A−B), 8 xor, 9 or, 10 and, 11 A and not B, 12 nand.
- R4: Operation 1 adds the sign-extended immediate `[31:18]` to A.
- R5: Operation 2 (bitfield move) shifts B right logically by the source bit position and masks it. The result is A with the masked field at the destination bit position replaced by that value.
- R6: Operation 3 shifts B right logically by the full 32-bit value of A, masks it, and shifts it left by the destination bit position. A shift of 32 or more gives 0.
- R7: Operation 4 shifts B right logically by the source bit position, masks it, and shifts it left by the full 32-bit value of A.
- R8: Action 1 writes the next FIFO parameter to the destination register and sends the result as a method write in the same cycle. If the FIFO is empty the instruction stalls. When `prm_done` is high with the FIFO empty, the instruction retires with a parameter of 0 and consumes nothing.
- R9: Action 0 writes the result to the destination register. Action 2 also loads the method address with result bits `[MW-1:0]`. Action 3 writes the result and sends it to the current method address. Actions 1 and 3 then increment the method address.
- R10: A branch tests A against zero: taken when A==0 with bit 4 clear, or when A!=0 with bit 4 set. Its target is the program base plus the immediate times 4. With bit 5 clear, the following instruction (the delay slot) executes before the redirect, and a branch placed in a delay slot has no effect.
- R11: With bit 5 set, a taken branch redirects at once, with no delay slot.
- R12: `busy` falls once an instruction with the exit bit retires. An exit-marked taken branch that has a delay slot first retires its delay slot. An exit-marked delay-slot instruction also ends the run.
- R13: Operations 5 and 6, and undefined ALU codes, pulse `err` for one cycle when they retire. They write no register, send no method write and consume no parameter.
- R14: `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| start_addr | input | AW | Byte address of the first instruction and program base |
| busy | output | 1 | A run is in progress |
| imem_addr | output | AW | Instruction byte address; data is returned one cycle later |
| imem_data | input | 32 | Instruction word |
| prm_valid | input | 1 | Parameter FIFO holds a value |
| prm_data | input | 32 | Head of the parameter FIFO |
| prm_done | input | 1 | Upstream has no more parameters |
| prm_ready | output | 1 | Head parameter consumed this cycle |
| mw_valid | output | 1 | Method write issued |
| mw_addr | output | MW | Method address |
| mw_data | output | 32 | Method value |
| err | output | 1 | Undefined operation retired |

## Verification
A parameter fetch and a method write can retire in the same cycle. An action-1 instruction both consumes a FIFO value into its destination register and emits its computed result. The bench provokes this with a full FIFO, then with an empty FIFO that fills late, then with the upstream source closed. The model predicts the combined `prm_ready`, `mw_valid`, address and data on every clock, and also the cycles the core holds while it waits.

// File: rtl/macro_core.sv
module macro_core #(
  parameter int AW = 14,
  parameter int MW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic [AW-1:0] imem_addr,
  input  logic [31:0]   imem_data,
  input  logic          prm_valid,
  input  logic [31:0]   prm_data,
  input  logic          prm_done,
  output logic          prm_ready,
  output logic          mw_valid,
  output logic [MW-1:0] mw_addr,
  output logic [31:0]   mw_data,
  output logic          err
);
  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} st_t;
  st_t st;

  logic [AW-1:0] pc, base, dtgt, tgt, pc_nx;
  logic          dly, xpend;
  logic [31:0]   rf [8];
  logic [MW-1:0] maddr;

  logic [2:0]  op, rd, ra, rb;
  logic [1:0]  act;
  logic [4:0]  fn, sb, wd, db;
  logic        ex, isbr, bad, stall, go, eff, tk, stop;
  logic [31:0] imm, va, vb, mask, res, wdat;

  assign op   = imem_data[2:0];
  assign ex   = imem_data[3];
  assign act  = imem_data[5:4];
  assign rd   = imem_data[8:6];
  assign ra   = imem_data[11:9];
  assign rb   = imem_data[14:12];
  assign fn   = imem_data[19:15];
  assign sb   = imem_data[19:15];
  assign wd   = imem_data[24:20];
  assign db   = imem_data[29:25];
  assign imm  = {{18{imem_data[31]}}, imem_data[31:18]};
  assign va   = rf[ra];
  assign vb   = rf[rb];
  assign mask = (32'd1 << wd) - 32'd1;
  assign tgt  = base + {imm[AW-3:0], 2'b00};

  always_comb begin
    res = '0;
    bad = 1'b0;
    case (op)
      3'd0: begin
        case (fn)
          5'd0:    res = va + vb;
          5'd1:    res = va - vb;
          5'd8:    res = va ^ vb;
          5'd9:    res = va | vb;
          5'd10:   res = va & vb;
          5'd11:   res = va & ~vb;
          5'd12:   res = ~(va & vb);
          default: bad = 1'b1;
        endcase
      end
      3'd1: res = va + imm;
      3'd2: res = (va & ~(mask << db)) | (((vb >> sb) & mask) << db);
      3'd3: res = ((vb >> va) & mask) << db;
      3'd4: res = ((vb >> sb) & mask) << va;
      3'd7: res = '0;
      default: bad = 1'b1;
    endcase
  end

  assign isbr  = (op == 3'd7);
  assign stall = (st == S_EXEC) && !isbr && !bad && (act == 2'd1) && !prm_valid && !prm_done;
  assign go    = (st == S_EXEC) && !stall;
  assign eff   = go && !isbr && !bad;
  assign tk    = go && isbr && !dly && ((va == 32'd0) ^ imem_data[4]);
  assign stop  = go && (dly ? (xpend || ex) : (ex && !(tk && !imem_data[5])));
  assign pc_nx = dly ? dtgt : (tk && imem_data[5]) ? tgt : pc + AW'(4);
  assign wdat  = (act == 2'd1) ? (prm_valid ? prm_data : 32'd0) : res;

  assign busy      = (st != S_IDLE);
  assign imem_addr = pc;
  assign prm_ready = eff && (act == 2'd1) && prm_valid;
  assign mw_valid  = eff && act[0];
  assign mw_addr   = maddr;
  assign mw_data   = res;
  assign err       = go && !isbr && bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pc    <= '0;
      base  <= '0;
      dtgt  <= '0;
      dly   <= 1'b0;
      xpend <= 1'b0;
      maddr <= '0;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_FETCH;
          pc    <= start_addr;
          base  <= start_addr;
          dly   <= 1'b0;
          xpend <= 1'b0;
        end
        S_FETCH: st <= S_EXEC;
        default: if (go) begin
          st    <= stop ? S_IDLE : S_FETCH;
          pc    <= pc_nx;
          dly   <= tk && !imem_data[5];
          xpend <= ex && tk && !imem_data[5];
          if (tk) dtgt <= tgt;
          if (eff) begin
            rf[rd] <= wdat;
            if (act == 2'd2) maddr <= res[MW-1:0];
            else if (act[0]) maddr <= maddr + 1'b1;
          end
        end
      endcase
    end
  end

  // R1
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (busy && imem_addr == $past(start_addr)));

  // R2
  seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !stop && !tk && !dly) |=> (imem_addr == $past(pc) + AW'(4)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (busy && $stable(imem_addr)));

  // R8
  prm_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prm_ready |-> (prm_valid && mw_valid));

  // R9
  mw_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid |-> busy);

  // R13
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mw_valid && !prm_ready));

  // R14
  start_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && st == S_FETCH) |=> $stable(imem_addr));
endmodule

// File: tb/macro_core_tb.sv
module macro_core_tb;
  localparam int AW = 14;
  localparam int MW = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic busy, prm_valid, prm_ready, mw_valid, err;
  logic prm_done = 1'b0, gate = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [31:0] imem_data = '0, prm_data, mw_data;
  logic [MW-1:0] mw_addr;

  logic [31:0] mem [0:255];
  logic [31:0] pq [0:15];
  int hd = 0, tl = 0;
  int checks = 0, errors = 0;
  string req = "R1";

  always #10 clk = ~clk;

  macro_core #(.AW(AW), .MW(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .imem_addr(imem_addr), .imem_data(imem_data), .prm_valid(prm_valid),
    .prm_data(prm_data), .prm_done(prm_done), .prm_ready(prm_ready),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .err(err));

  always @(posedge clk) imem_data <= mem[imem_addr[9:2]];
  assign prm_valid = gate && (hd != tl);
  assign prm_data  = pq[hd % 16];
  always @(posedge clk) if (prm_ready) hd <= hd + 1;

  task automatic chk(input bit ok, input string what, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, a, e);
    end
  endtask

  // reference model state
  int ms = 0;
  logic [AW-1:0] mpc = '0, mbase = '0, mdt = '0;
  logic mdp = 1'b0, mxp = 1'b0;
  logic [31:0] mr [8];
  logic [MW-1:0] mma = '0;
  logic e_mwv, e_err, e_rdy;
  logic [31:0] e_mwd;

  function automatic bit calc(input logic [31:0] w, input logic [31:0] va, input logic [31:0] vb,
                              output logic [31:0] r);
    int o = int'(w[2:0]);
    int f = int'(w[19:15]);
    int n = int'(w[24:20]);
    logic [31:0] s = 32'(w[19:15]);
    logic [31:0] d = 32'(w[29:25]);
    logic [31:0] m = (n == 0) ? 32'd0 : (32'hffff_ffff >> (32 - n));
    logic [31:0] im = 32'($signed(w[31:18]));
    r = 32'd0;
    if (o == 0) begin
      if (f == 0) r = va + vb;
      else if (f == 1) r = va - vb;
      else if (f == 8) r = va ^ vb;
      else if (f == 9) r = va | vb;
      else if (f == 10) r = va & vb;
      else if (f == 11) r = va & ~vb;
      else if (f == 12) r = ~(va & vb);
      else return 1'b0;
    end else if (o == 1) r = va + im;
    else if (o == 2) r = (va & ~(m << d)) | (((vb >> s) & m) << d);
    else if (o == 3) r = ((vb >> va) & m) << d;
    else if (o == 4) r = ((vb >> s) & m) << va;
    else if (o != 7) return 1'b0;
    return 1'b1;
  endfunction

  task automatic exec_model();
    logic [31:0] w, va, vb, r, wv;
    logic [AW-1:0] tgt;
    bit ok, isb, taken, stop;
    int act;
    w   = mem[mpc[9:2]];
    va  = mr[w[11:9]];
    vb  = mr[w[14:12]];
    isb = (w[2:0] == 3'd7);
    act = int'(w[5:4]);
    ok  = calc(w, va, vb, r);
    if (!isb && ok && act == 1 && !prm_valid && !prm_done) return;
    taken = 1'b0;
    tgt = mbase + AW'($signed(w[31:18]) * 4);
    if (isb && !mdp) taken = w[4] ? (va != 0) : (va == 0);
    if (!isb && !ok) e_err = 1'b1;
    if (!isb && ok) begin
      wv = r;
      if (act == 1) begin
        e_mwv = 1'b1; e_mwd = r; e_rdy = prm_valid;
        wv = prm_valid ? prm_data : 32'd0;
        mma = mma + 1'b1;
      end else if (act == 3) begin
        e_mwv = 1'b1; e_mwd = r; mma = mma + 1'b1;
      end else if (act == 2) mma = r[MW-1:0];
      mr[w[8:6]] = wv;
    end
    stop = 1'b0;
    if (mdp) begin
      mpc = mdt; mdp = 1'b0; stop = mxp || w[3]; mxp = 1'b0;
    end else if (taken && w[5]) begin
      mpc = tgt; stop = w[3];
    end else if (taken) begin
      mpc = mpc + AW'(4); mdp = 1'b1; mdt = tgt; mxp = w[3];
    end else begin
      mpc = mpc + AW'(4); stop = w[3];
    end
    ms = stop ? 0 : 1;
  endtask

  logic [MW-1:0] ma_prev;
  always @(negedge clk) begin
    if (!rst_n) begin
      ms = 0; mpc = '0; mbase = '0; mdt = '0; mdp = 1'b0; mxp = 1'b0; mma = '0;
      for (int i = 0; i < 8; i++) mr[i] = '0;
    end else begin
      e_mwv = 1'b0; e_err = 1'b0; e_rdy = 1'b0; e_mwd = '0; ma_prev = mma;
      chk(busy === (ms != 0), "busy", 32'(busy), 32'(ms != 0));
      if (ms != 0) chk(imem_addr === mpc, "imem_addr", 32'(imem_addr), 32'(mpc));
      if (ms == 0) begin
        if (start) begin ms = 1; mpc = start_addr; mbase = start_addr; mdp = 1'b0; mxp = 1'b0; end
      end else if (ms == 1) ms = 2;
      else exec_model();
      chk(mw_valid === e_mwv, "mw_valid", 32'(mw_valid), 32'(e_mwv));
      if (e_mwv) begin
        chk(mw_addr === ma_prev, "mw_addr", 32'(mw_addr), 32'(ma_prev));
        chk(mw_data === e_mwd, "mw_data", mw_data, e_mwd);
      end
      chk(err === e_err, "err", 32'(err), 32'(e_err));
      chk(prm_ready === e_rdy, "prm_ready", 32'(prm_ready), 32'(e_rdy));
    end
  end

  function automatic logic [31:0] i_alu(int fn, int rd, int ra, int rb, int act, int ex);
    return {12'd0, 5'(fn), 3'(rb), 3'(ra), 3'(rd), 2'(act), 1'(ex), 3'd0};
  endfunction
  function automatic logic [31:0] i_addi(int rd, int ra, int imm, int act, int ex);
    return {14'(imm), 6'd0, 3'(ra), 3'(rd), 2'(act), 1'(ex), 3'd1};
  endfunction
  function automatic logic [31:0] i_bf(int op, int rd, int ra, int rb, int sb, int w, int db, int act, int ex);
    return {2'd0, 5'(db), 5'(w), 5'(sb), 3'(rb), 3'(ra), 3'(rd), 2'(act), 1'(ex), 3'(op)};
  endfunction
  function automatic logic [31:0] i_br(int ra, int ne, int nod, int imm, int ex);
    return {14'(imm), 6'd0, 3'(ra), 3'd0, 1'(nod), 1'(ne), 1'(ex), 3'd7};
  endfunction

  task automatic launch(input int addr);
    @(posedge clk); #1 start = 1'b1; start_addr = AW'(addr);
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    chk(!busy, "run did not finish", 32'(busy), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL %s watchdog: got %h expected %h", req, 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
    // T2 at word 0: R3 R4 R9
    mem[0]  = i_addi(7, 7, 64, 2, 0);
    mem[1]  = i_addi(1, 1, 100, 0, 0);
    mem[2]  = i_addi(2, 2, -7, 3, 0);
    mem[3]  = i_alu(0, 3, 1, 2, 3, 0);
    mem[4]  = i_alu(1, 3, 1, 2, 3, 0);
    mem[5]  = i_alu(8, 3, 1, 2, 3, 0);
    mem[6]  = i_alu(9, 3, 1, 2, 3, 0);
    mem[7]  = i_alu(10, 3, 1, 2, 3, 0);
    mem[8]  = i_alu(11, 3, 1, 2, 3, 0);
    mem[9]  = i_alu(12, 4, 1, 2, 3, 1);
    // T3 at word 16: R5 R6 R7
    mem[16] = i_addi(1, 0, 6844, 0, 0);
    mem[17] = i_alu(1, 1, 1, 0, 0, 0);
    mem[18] = i_addi(1, 1, 6844, 0, 0);
    mem[19] = i_alu(12, 2, 0, 0, 0, 0);
    mem[20] = i_alu(11, 2, 2, 3, 0, 0);
    mem[21] = i_alu(1, 4, 4, 4, 0, 0);
    mem[22] = i_addi(4, 4, 4, 0, 0);
    mem[23] = i_alu(1, 5, 5, 5, 0, 0);
    mem[24] = i_addi(5, 5, 40, 0, 0);
    mem[25] = i_bf(2, 2, 2, 1, 4, 8, 12, 3, 0);
    mem[26] = i_bf(3, 3, 4, 1, 0, 8, 16, 3, 0);
    mem[27] = i_bf(4, 3, 4, 1, 8, 4, 0, 3, 0);
    mem[28] = i_bf(3, 6, 5, 1, 0, 8, 0, 3, 0);
    mem[29] = i_bf(4, 6, 5, 1, 0, 8, 0, 3, 1);
    // T4 at word 32: R8
    mem[32] = i_addi(7, 7, 128, 2, 0);
    mem[33] = i_addi(1, 1, 5, 1, 0);
    mem[34] = i_alu(0, 2, 1, 1, 1, 0);
    mem[35] = i_alu(0, 3, 2, 1, 1, 0);
    mem[36] = i_alu(0, 4, 3, 1, 1, 0);
    mem[37] = i_alu(0, 5, 4, 3, 3, 1);
    // T5 at word 48: R10 R11 R12
    mem[48] = i_addi(7, 7, 192, 2, 0);
    mem[49] = i_alu(1, 1, 1, 1, 0, 0);
    mem[50] = i_alu(1, 2, 2, 2, 0, 0);
    mem[51] = i_addi(1, 1, 3, 0, 0);
    mem[52] = i_addi(1, 1, -1, 3, 0);
    mem[53] = i_br(1, 1, 0, 4, 0);
    mem[54] = i_addi(2, 2, 1, 3, 0);
    mem[55] = i_br(1, 0, 1, 9, 0);
    mem[56] = i_addi(6, 6, 99, 3, 0);
    mem[57] = i_br(1, 0, 0, 12, 0);
    mem[58] = i_br(1, 0, 1, 8, 0);
    mem[59] = i_addi(6, 6, 55, 3, 0);
    mem[60] = i_br(1, 1, 0, 8, 0);
    mem[61] = i_br(1, 0, 0, 8, 1);
    mem[62] = i_addi(3, 2, 7, 3, 0);
    // T6 at word 80: R13 R12
    mem[80] = i_addi(7, 7, 320, 2, 0);
    mem[81] = i_alu(1, 4, 4, 4, 0, 0);
    mem[82] = i_alu(5, 4, 1, 2, 3, 0);
    mem[83] = i_bf(6, 4, 1, 2, 0, 4, 0, 3, 0);
    mem[84] = i_bf(5, 4, 1, 2, 0, 4, 0, 1, 0);
    mem[85] = i_addi(5, 4, 0, 3, 0);
    mem[86] = i_br(4, 0, 0, 9, 0);
    mem[87] = i_addi(5, 5, 1, 3, 1);
    mem[88] = i_addi(5, 5, 77, 3, 0);
    mem[89] = i_addi(5, 5, 88, 3, 1);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    chk(busy === 1'b0, "reset busy", 32'(busy), 32'd0);
    chk(mw_valid === 1'b0, "reset mw_valid", 32'(mw_valid), 32'd0);
    chk(err === 1'b0, "reset err", 32'(err), 32'd0);
    chk(prm_ready === 1'b0, "reset prm_ready", 32'(prm_ready), 32'd0);

    req = "R1 R2 R3 R4 R9"; launch(0); wait_idle();
    req = "R5 R6 R7"; launch(64); wait_idle();

    req = "R8";
    pq[0] = 32'h11; pq[1] = 32'h22; tl = 2;
    launch(128);
    repeat (30) @(posedge clk);
    #1 pq[2] = 32'h33; tl = 3;
    repeat (20) @(posedge clk);
    #1 prm_done = 1'b1;
    wait_idle();
    #1 prm_done = 1'b0;

    req = "R10 R11 R12"; launch(192); wait_idle();
    req = "R13 R12"; launch(320); wait_idle();

    req = "R14";
    launch(192);
    repeat (9) @(posedge clk);
    #1 start = 1'b1; start_addr = '0;
    @(posedge clk); #1 start = 1'b0;
    wait_idle();

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule